// File: doc/BRIEF.md
# Register-Mapped Pin and Event Expander

This block sits between a host register bus and a set of board pins. The host writes whole banks of output pins and reads back the live levels of banks of input pins. A separate group of up to sixteen event sources, each a plain level signal, is watched for rising edges. Every edge is latched as a pending bit. The pending bits appear together in one status register, and one upstream interrupt line is raised while any bit is pending.

The host clears the pending bits by writing one fixed clearing value to the status register. That value is all-ones by default, and all-zeros when the inverted-clear parameter is set. The block has no per-source enable: the host filters the events it does not want. The output registers come out of reset with parameterised initial values. The host can rewrite them at any time, for example after the pin supply has been cycled.

The host port is a simple synchronous register port, not a stream. A request is taken in every cycle in which `bus_en_i` is high, so there is no back-pressure. Read data is registered and appears one cycle after the request.

Top module: `gpio_irq_expander`

## Requirements
- R1: After reset `pin_out_o` equals `OUT_INIT`, `irq_o` is low, `bus_rdata_o` is zero and the status register reads zero.
- R2: Register index i sits at byte address i<<1 when `BUS_W` is 16, or i<<2 when `BUS_W` is 32. Reads of a misaligned address, or of an index with no register, return zero. Writes to such addresses change nothing.
- R3: Output register k (index k, for k below `N_OUT`) drives `pin_out_o[k*REG_W +: REG_W]`. A write replaces all `REG_W` bits with `bus_wdata_i[REG_W-1:0]`, and the new value is on the pins one cycle after the write.
- R4: Input register j (index `IN_BASE`+j) returns `pin_in_i[j*REG_W +: REG_W]` after a two-flop synchronizer. A level that has been held for three cycles is returned by a read.
- R5: Writes to input registers are ignored: `pin_out_o` and all reads are unaffected.
- R6: A rising edge on synchronized `evt_src_i[i]` sets pending bit i. This bit is read at bit i of the status register (index `ACK_IDX`). It stays set until it is cleared. Falling edges and steady high levels set nothing.
- R7: A write to the status register clears every pending bit only when the data equals the clearing value: 16'hFFFF when `ACK_INV` is 0, or 16'h0000 when `ACK_INV` is 1. Any other data leaves the pending bits unchanged.
- R8: When an edge is detected in the same cycle as a clearing write, that edge's pending bit stays set.
- R9: `irq_o` is high exactly while at least one pending bit is set. It therefore rises again after a clear as soon as a new event is latched.
- R10: Data bits above `REG_W` in register reads, and above `N_IRQ` in status reads, are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_en_i | input | 1 | Register access request this cycle |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | AW | Byte address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, valid the cycle after a read request |
| pin_in_i | input | N_IN*REG_W | Asynchronous input pin levels |
| pin_out_o | output | N_OUT*REG_W | Output pin levels |
| evt_src_i | input | N_IRQ | Asynchronous event source levels |
| irq_o | output | 1 | Upstream interrupt, high while any event is pending |

## Verification
The assertions assume that `evt_src_i` is low while reset is active, so that the first synchronized sample cannot count as an edge. They also assume that the host issues at most one access per cycle. The stimulus holds the sources at zero through reset. It drives each access for exactly one cycle and waits at least three cycles after changing a source before it relies on the result. Only the same-cycle case of R8 deliberately places a clearing write on the edge-detect cycle.

// File: rtl/gx_pkg.sv
package gx_pkg;
  typedef enum logic [1:0] {SEL_NONE, SEL_OUT, SEL_IN, SEL_ACK} sel_e;

  function automatic int addr_shift(input int bus_w);
    return (bus_w == 32) ? 2 : 1;
  endfunction
endpackage

// File: rtl/gx_sync.sv
module gx_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st[s] <= '0;
    end else begin
      st[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st[s] <= st[s-1];
    end
  end

  assign q_o = st[STAGES-1];
endmodule

// File: rtl/gx_decode.sv
module gx_decode #(
  parameter int BUS_W   = 16,
  parameter int AW      = 8,
  parameter int N_OUT   = 2,
  parameter int N_IN    = 2,
  parameter int IN_BASE = 2,
  parameter int ACK_IDX = 4
) (
  input  logic [AW-1:0]    addr_i,
  output gx_pkg::sel_e     sel_o,
  output logic [7:0]       sub_o
);
  localparam int ASH = gx_pkg::addr_shift(BUS_W);

  always_comb begin
    int ix;
    ix    = int'(addr_i >> ASH);
    sel_o = gx_pkg::SEL_NONE;
    sub_o = '0;
    if (addr_i[ASH-1:0] == '0) begin
      if (ix < N_OUT) begin
        sel_o = gx_pkg::SEL_OUT;
        sub_o = 8'(ix);
      end else if (ix >= IN_BASE && ix < IN_BASE + N_IN) begin
        sel_o = gx_pkg::SEL_IN;
        sub_o = 8'(ix - IN_BASE);
      end else if (ix == ACK_IDX) begin
        sel_o = gx_pkg::SEL_ACK;
      end
    end
  end
endmodule

// File: rtl/gx_event.sv
module gx_event #(
  parameter int N       = 8,
  parameter bit ACK_INV = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] src_i,
  input  logic         ack_wr_i,
  input  logic [15:0]  ack_data_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] rise_o,
  output logic         ack_hit_o,
  output logic         irq_o
);
  localparam logic [15:0] CLEAR_VAL = ACK_INV ? 16'h0000 : 16'hFFFF;

  logic [N-1:0] prev_q;
  logic [N-1:0] pend_q;

  assign rise_o    = src_i & ~prev_q;
  assign ack_hit_o = ack_wr_i && (ack_data_i == CLEAR_VAL);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      prev_q <= '0;
      pend_q <= '0;
    end else begin
      prev_q <= src_i;
      // a fresh edge is ORed in after the clear, so it survives
      pend_q <= (ack_hit_o ? '0 : pend_q) | rise_o;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |pend_q;
endmodule

// File: rtl/gpio_irq_expander.sv
module gpio_irq_expander #(
  parameter int BUS_W   = 16,
  parameter int REG_W   = 8,
  parameter int N_OUT   = 2,
  parameter int N_IN    = 2,
  parameter int N_IRQ   = 8,
  parameter int AW      = 8,
  parameter int IN_BASE = 2,
  parameter int ACK_IDX = 4,
  parameter bit ACK_INV = 1'b0,
  parameter logic [N_OUT*REG_W-1:0] OUT_INIT = '0
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   bus_en_i,
  input  logic                   bus_we_i,
  input  logic [AW-1:0]          bus_addr_i,
  input  logic [15:0]            bus_wdata_i,
  output logic [15:0]            bus_rdata_o,
  input  logic [N_IN*REG_W-1:0]  pin_in_i,
  output logic [N_OUT*REG_W-1:0] pin_out_o,
  input  logic [N_IRQ-1:0]       evt_src_i,
  output logic                   irq_o
);
  logic [N_IN*REG_W-1:0] in_sync;
  logic [N_IRQ-1:0]      src_sync;
  logic [N_IRQ-1:0]      pend, rise;
  logic                  ack_hit;
  gx_pkg::sel_e          sel;
  logic [7:0]            sub;
  logic                  wr;
  logic [REG_W-1:0]      out_q [N_OUT];
  logic [15:0]           rd_val, rdata_q;

  gx_sync #(.W(N_IN*REG_W), .STAGES(2)) u_in_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pin_in_i), .q_o(in_sync));

  gx_sync #(.W(N_IRQ), .STAGES(2)) u_src_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(evt_src_i), .q_o(src_sync));

  gx_decode #(.BUS_W(BUS_W), .AW(AW), .N_OUT(N_OUT), .N_IN(N_IN),
              .IN_BASE(IN_BASE), .ACK_IDX(ACK_IDX)) u_dec (
    .addr_i(bus_addr_i), .sel_o(sel), .sub_o(sub));

  assign wr = bus_en_i && bus_we_i;

  gx_event #(.N(N_IRQ), .ACK_INV(ACK_INV)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_sync),
    .ack_wr_i(wr && sel == gx_pkg::SEL_ACK), .ack_data_i(bus_wdata_i),
    .pend_o(pend), .rise_o(rise), .ack_hit_o(ack_hit), .irq_o(irq_o));

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    always_ff @(posedge clk_i) begin
      if (!rst_ni)
        out_q[k] <= OUT_INIT[k*REG_W +: REG_W];
      else if (wr && sel == gx_pkg::SEL_OUT && int'(sub) == k)
        out_q[k] <= bus_wdata_i[REG_W-1:0];
    end
    assign pin_out_o[k*REG_W +: REG_W] = out_q[k];
  end

  always_comb begin
    rd_val = '0;
    unique case (sel)
      gx_pkg::SEL_OUT:
        for (int k = 0; k < N_OUT; k++)
          if (int'(sub) == k) rd_val = 16'(out_q[k]);
      gx_pkg::SEL_IN:
        for (int j = 0; j < N_IN; j++)
          if (int'(sub) == j) rd_val = 16'(in_sync[j*REG_W +: REG_W]);
      gx_pkg::SEL_ACK: rd_val = 16'(pend);
      default: rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= (bus_en_i && !bus_we_i) ? rd_val : '0;
  end

  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/gx_checker.sv
module gx_checker #(
  parameter int BUS_W   = 16,
  parameter int AW      = 8,
  parameter int N_OUT   = 2,
  parameter int N_IN    = 2,
  parameter int N_IRQ   = 8,
  parameter int REG_W   = 8,
  parameter int IN_BASE = 2,
  parameter int ACK_IDX = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   bus_en_i,
  input logic                   bus_we_i,
  input logic [AW-1:0]          bus_addr_i,
  input logic [15:0]            bus_rdata_o,
  input logic [N_OUT*REG_W-1:0] pin_out_o,
  input logic                   irq_o,
  input logic [N_IRQ-1:0]       pend,
  input logic [N_IRQ-1:0]       rise,
  input logic                   ack_hit
);
  localparam int ASH = (BUS_W == 32) ? 2 : 1;

  logic in_hit, mapped;
  always_comb begin
    in_hit = 1'b0;
    mapped = 1'b0;
    for (int i = 0; i < N_OUT; i++)
      if (int'(bus_addr_i) == (i << ASH)) mapped = 1'b1;
    for (int j = 0; j < N_IN; j++)
      if (int'(bus_addr_i) == ((IN_BASE + j) << ASH)) in_hit = 1'b1;
    if (int'(bus_addr_i) == (ACK_IDX << ASH)) mapped = 1'b1;
    mapped = mapped || in_hit;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!rst_ni) |-> !irq_o); // R1
  AST_UNMAPPED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && !bus_we_i && !mapped) |=> (bus_rdata_o == '0)); // R2
  AST_IN_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_en_i && bus_we_i && in_hit) |=> $stable(pin_out_o)); // R5
  AST_PEND_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_hit |=> ((pend & $past(pend)) == $past(pend))); // R6
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_hit && rise == '0) |=> (pend == '0)); // R7
  AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise != '0) |=> ((pend & $past(rise)) == $past(rise))); // R8
  AST_IRQ_ROSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rise != '0)); // R9
endmodule

bind gpio_irq_expander gx_checker #(
  .BUS_W(BUS_W), .AW(AW), .N_OUT(N_OUT), .N_IN(N_IN), .N_IRQ(N_IRQ),
  .REG_W(REG_W), .IN_BASE(IN_BASE), .ACK_IDX(ACK_IDX)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_en_i(bus_en_i), .bus_we_i(bus_we_i),
  .bus_addr_i(bus_addr_i), .bus_rdata_o(bus_rdata_o), .pin_out_o(pin_out_o),
  .irq_o(irq_o), .pend(pend), .rise(rise), .ack_hit(ack_hit));

// File: tb/test_gpio_irq_expander.sv
module test_gpio_irq_expander;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // main instance: 16-bit bus, 8-bit registers, all-ones clear
  logic        en_a = 0, we_a = 0;
  logic [7:0]  addr_a = 0;
  logic [15:0] wd_a = 0, rd_a;
  logic [15:0] pin_in_a = 0, pin_out_a;
  logic [7:0]  src_a = 0;
  logic        irq_a;

  // variant: 32-bit bus, 16-bit registers, all-zeros clear
  logic        en_b = 0, we_b = 0;
  logic [7:0]  addr_b = 0;
  logic [15:0] wd_b = 0, rd_b;
  logic [15:0] pin_in_b = 0, pin_out_b;
  logic [15:0] src_b = 0;
  logic        irq_b;

  gpio_irq_expander #(.BUS_W(16), .REG_W(8), .N_OUT(2), .N_IN(2), .N_IRQ(8),
    .AW(8), .IN_BASE(2), .ACK_IDX(4), .ACK_INV(1'b0), .OUT_INIT(16'hA55A))
  i_gpio_irq_expander (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en_a), .bus_we_i(we_a),
    .bus_addr_i(addr_a), .bus_wdata_i(wd_a), .bus_rdata_o(rd_a),
    .pin_in_i(pin_in_a), .pin_out_o(pin_out_a), .evt_src_i(src_a), .irq_o(irq_a));

  gpio_irq_expander #(.BUS_W(32), .REG_W(16), .N_OUT(1), .N_IN(1), .N_IRQ(16),
    .AW(8), .IN_BASE(1), .ACK_IDX(2), .ACK_INV(1'b1), .OUT_INIT(16'h1234))
  i_gpio_irq_expander_alt (
    .clk_i(clk), .rst_ni(rst_n), .bus_en_i(en_b), .bus_we_i(we_b),
    .bus_addr_i(addr_b), .bus_wdata_i(wd_b), .bus_rdata_o(rd_b),
    .pin_in_i(pin_in_b), .pin_out_o(pin_out_b), .evt_src_i(src_b), .irq_o(irq_b));

  int n_vec = 0, n_fail = 0;
  logic [15:0] exp_out, exp_pend;
  logic [15:0] rv;

  function automatic logic [15:0] edges(input logic [15:0] prev, input logic [15:0] now);
    return now & ~prev;
  endfunction

  function automatic logic [15:0] after_ack(input logic [15:0] pend, input logic [15:0] d,
                                            input bit inv);
    return (d == (inv ? 16'h0000 : 16'hFFFF)) ? 16'h0000 : pend;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at a falling edge
  task automatic bus_wr(input bit alt, input logic [7:0] a, input logic [15:0] d);
    if (alt) begin en_b = 1; we_b = 1; addr_b = a; wd_b = d; end
    else     begin en_a = 1; we_a = 1; addr_a = a; wd_a = d; end
    @(posedge clk); #1;
    en_a = 0; we_a = 0; en_b = 0; we_b = 0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input bit alt, input logic [7:0] a, output logic [15:0] d);
    if (alt) begin en_b = 1; we_b = 0; addr_b = a; end
    else     begin en_a = 1; we_a = 0; addr_a = a; end
    @(posedge clk); #1;
    d = alt ? rd_b : rd_a;
    en_a = 0; en_b = 0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check("R1 pins", pin_out_a, 16'hA55A);
    check("R1 alt pins", pin_out_b, 16'h1234);
    check("R1 irq", irq_a, 0);
    check("R1 rdata", rd_a, 0);
    bus_rd(0, 8'h08, rv); check("R1 status", rv, 0);
    exp_out  = 16'hA55A;
    exp_pend = 0;

    // R3 R10 readback of output register (16-bit bus: index 1 -> addr 2)
    bus_rd(0, 8'h02, rv); check("R10 out readback", rv, 16'h00A5);

    // R6 falling edge sets nothing
    src_a = 8'h10; settle(); exp_pend = edges(0, 16'h10);
    bus_wr(0, 8'h08, 16'hFFFF); exp_pend = 0;
    src_a = 8'h00; settle();
    bus_rd(0, 8'h08, rv); check("R6 falling edge", rv, 0);

    // R8 R9 edge in same cycle as clear survives
    src_a = 8'h01;
    @(negedge clk); @(negedge clk);
    bus_wr(0, 8'h08, 16'hFFFF);
    bus_rd(0, 8'h08, rv); check("R8 same-cycle edge", rv, 16'h0001);
    check("R9 irq after clear", irq_a, 1);
    exp_pend = 16'h0001;

    // R7 non-clearing value ignored
    bus_wr(0, 8'h08, 16'h00FF);
    bus_rd(0, 8'h08, rv); check("R7 other value", rv, exp_pend);
    bus_wr(0, 8'h08, 16'hFFFF); exp_pend = 0;
    check("R9 irq low after clear", irq_a, 0);

    // R2 R5 misaligned and input write
    bus_wr(0, 8'h01, 16'h0000);
    check("R2 misaligned write", pin_out_a, exp_out);
    bus_wr(0, 8'h04, 16'h0000);
    check("R5 input write", pin_out_a, exp_out);

    // variant instance: 32-bit addressing, 16-bit regs, inverted clear
    bus_wr(1, 8'h00, 16'hBEEF); check("R3 alt full write", pin_out_b, 16'hBEEF);
    pin_in_b = 16'hC3C3; settle();
    bus_rd(1, 8'h04, rv); check("R4 alt input", rv, 16'hC3C3);
    bus_rd(1, 8'h02, rv); check("R2 alt misaligned", rv, 0);
    src_b = 16'h8000; settle();
    bus_rd(1, 8'h08, rv); check("R6 alt status", rv, 16'h8000);
    bus_wr(1, 8'h08, 16'hFFFF);
    bus_rd(1, 8'h08, rv); check("R7 alt ones kept", rv, 16'h8000);
    bus_wr(1, 8'h08, 16'h0000);
    bus_rd(1, 8'h08, rv); check("R7 alt zeros clear", rv, 0);
    check("R9 alt irq", irq_b, 0);

    // random mix on the main instance
    for (int it = 0; it < 400; it++) begin
      int op;
      op = int'($urandom % 5);
      case (op)
        0: begin : wr_out
          int k; logic [15:0] d;
          k = int'($urandom % 2); d = 16'($urandom);
          bus_wr(0, 8'(k << 1), d);
          exp_out[k*8 +: 8] = d[7:0];
          check("R3 output write", pin_out_a, exp_out);
        end
        1: begin : rd_in
          int j;
          j = int'($urandom % 2);
          pin_in_a = 16'($urandom); settle();
          bus_rd(0, 8'((2 + j) << 1), rv);
          check("R4 input read", rv, {8'h00, pin_in_a[j*8 +: 8]});
        end
        2: begin : evt
          logic [7:0] nv;
          nv = 8'($urandom);
          exp_pend = exp_pend | edges({8'h00, src_a}, {8'h00, nv});
          src_a = nv; settle();
          bus_rd(0, 8'h08, rv);
          check("R6 status", rv, exp_pend);
          check("R9 irq", irq_a, exp_pend != 0);
        end
        3: begin : ack
          logic [15:0] d;
          d = ($urandom % 2) ? 16'hFFFF : 16'($urandom);
          bus_wr(0, 8'h08, d);
          exp_pend = after_ack(exp_pend, d, 1'b0);
          bus_rd(0, 8'h08, rv);
          check("R7 clear", rv, exp_pend);
        end
        default: begin : misc
          logic [7:0] a;
          bus_wr(0, 8'h06, 16'($urandom));
          check("R5 input write ignored", pin_out_a, exp_out);
          a = 8'(10 + ($urandom % 246));
          bus_rd(0, a, rv);
          check("R2 unmapped read", rv, 0);
        end
      endcase
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule